// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

The block watches four dedicated external interrupt lines and 27 general-purpose pins, and turns activity on them into interrupt requests for a CPU. Each external line has a sense mode: low level, any change, falling edge or rising edge. In the three edge modes a detected event latches a per-line flag. In level mode the flag stays zero, and the line requests directly while it is held low. The 27 pins form four pin-change groups: pins 7..0, 15..8, 23..16 and 26..24. Every pin has its own mask bit. A change in either direction on a masked-in pin latches its group's flag.

A request goes out when the source is active, the source's own enable is set and the global enable input `gie` is high. All eight requests are visible on `irq_req`. A fixed-priority encoder names the winning source on `vec_id`. A one-cycle `vec_ack` clears the flag of the source named in that cycle. Software can also clear flags by writing ones to the flag registers. Every pin input passes through a two-flop synchroniser before edge or change detection.

Register map (4-bit address, reads are combinational): 0 external flags (bits 3..0, write-one-to-clear), 1 external enables (bits 3..0), 2 external modes (two bits per line, line n at bits 2n+1:2n, 00 low level, 01 any change, 10 falling, 11 rising), 3 group enables (bits 3..0), 4 group flags (bits 3..0, write-one-to-clear), 5..8 pin masks of groups 0..3 (group 3 uses bits 2..0). Unused bits and unused addresses read zero.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_req` is zero and `vec_valid` is low.
- R2: In an edge mode, the line's flag (address 0) is set by the selected transition only: 11 rising, 10 falling, 01 either direction. The flag is readable three clock edges after the pin changes.
- R3: In level mode (00), the line's flag reads zero, including a flag that was set before the mode was selected. The line requests while its synchronised pin is low and stops two edges after the pin goes high.
- R4: `irq_req` bit n (external lines 0..3 in bits 3..0, groups 0..3 in bits 7..4) is high only when the source is active, its enable bit is set and `gie` is high.
- R5: Writing a one to a flag bit (addresses 0 and 4) clears it. Writing a zero leaves it unchanged.
- R6: A `vec_ack` while `vec_valid` is high clears the flag of the source named by `vec_id`, effective at that clock edge.
- R7: If a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: Bits 7..4 of addresses 0, 1, 3 and 4 read zero, and writes to them are ignored.
- R9: A change in either direction on a pin whose mask bit is set sets its group's flag. A change on a pin whose mask bit is clear leaves the flag unchanged.
- R10: The group 3 mask (address 8) holds only bits 2..0, which cover pins 26..24. Its other bits read zero.
- R11: `vec_valid` is high when any `irq_req` bit is set. `vec_id` is then the lowest set bit: external lines 0..3 first (ids 0..3), then groups 0..3 (ids 4..7).
- R12: Flags latch events whatever the enables and `gie` are. Enables only gate the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | External interrupt lines, asynchronous |
| pc_pin | input | 27 | Pin-change inputs, asynchronous |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_req | output | 8 | Per-source requests: ext 3..0, groups 7..4 |
| vec_valid | output | 1 | A request is pending |
| vec_id | output | 3 | Highest-priority pending source |
| vec_ack | input | 1 | Vector acknowledge pulse |

## Verification
The set-wins property assumes that the mode register is not rewritten in the same cycle as the colliding events. The bench never writes the mode while a pin is mid-synchronisation. The acknowledge property assumes `vec_ack` is a single-cycle pulse and that no new change lands on the acknowledged group in that cycle. The stimulus applies each pin change alone and waits out the synchroniser before the next acknowledge. Pins are held low through reset, so the synchroniser never sees a change at start-up.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int NEXT = 4,
  parameter int NPC  = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [NPC-1:0]   pc_pin,
  input  logic             gie,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [7:0]       irq_req,
  output logic             vec_valid,
  output logic [2:0]       vec_id,
  input  logic             vec_ack
);
  localparam int NGRP = 4;
  localparam int G3W  = NPC - 24;
  localparam logic [3:0] A_EFLG = 4'd0, A_EEN = 4'd1, A_EMODE = 4'd2, A_PCEN = 4'd3,
                         A_PCFLG = 4'd4, A_M0 = 4'd5, A_M1 = 4'd6, A_M2 = 4'd7, A_M3 = 4'd8;

  logic [NEXT-1:0] ext_s1, ext_s2, ext_s3;
  logic [NPC-1:0]  pc_s1, pc_s2, pc_s3;
  logic [NEXT-1:0] ext_flag, ext_en, ext_set, ext_clr, ext_lvl, ext_act;
  logic [2*NEXT-1:0] ext_mode;
  logic [NGRP-1:0] pc_flag, pc_en, pc_set, pc_clr;
  logic [7:0] pc_m0, pc_m1, pc_m2;
  logic [G3W-1:0] pc_m3;
  logic [NPC-1:0] pc_chg;
  logic [7:0] ack_hot;

  wire wr_eflg = bus_wr && bus_addr == A_EFLG;
  wire wr_pflg = bus_wr && bus_addr == A_PCFLG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_s1 <= '0; ext_s2 <= '0; ext_s3 <= '0;
      pc_s1 <= '0;  pc_s2 <= '0;  pc_s3 <= '0;
    end else begin
      ext_s1 <= ext_pin; ext_s2 <= ext_s1; ext_s3 <= ext_s2;
      pc_s1 <= pc_pin;   pc_s2 <= pc_s1;   pc_s3 <= pc_s2;
    end

  for (genvar i = 0; i < NEXT; i++) begin : g_ext
    wire [1:0] m = ext_mode[2*i+1:2*i];
    assign ext_lvl[i] = (m == 2'b00);
    assign ext_set[i] = (m == 2'b01) ? (ext_s2[i] ^ ext_s3[i]) :
                        (m == 2'b10) ? (ext_s3[i] & ~ext_s2[i]) :
                        (m == 2'b11) ? (ext_s2[i] & ~ext_s3[i]) : 1'b0;
    assign ext_act[i] = ext_lvl[i] ? ~ext_s2[i] : ext_flag[i];
  end

  assign ext_clr = (wr_eflg ? bus_wdata[NEXT-1:0] : '0) | ack_hot[3:0];
  assign pc_clr  = (wr_pflg ? bus_wdata[NGRP-1:0] : '0) | ack_hot[7:4];

  assign pc_chg = (pc_s2 ^ pc_s3) & {pc_m3, pc_m2, pc_m1, pc_m0};
  assign pc_set = {|pc_chg[NPC-1:24], |pc_chg[23:16], |pc_chg[15:8], |pc_chg[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_flag <= '0; ext_en <= '0; ext_mode <= '0;
      pc_flag <= '0;  pc_en <= '0;
      pc_m0 <= '0; pc_m1 <= '0; pc_m2 <= '0; pc_m3 <= '0;
    end else begin
      ext_flag <= ((ext_flag & ~ext_clr) | ext_set) & ~ext_lvl;
      pc_flag  <= (pc_flag & ~pc_clr) | pc_set;
      if (bus_wr)
        case (bus_addr)
          A_EEN:   ext_en   <= bus_wdata[NEXT-1:0];
          A_EMODE: ext_mode <= bus_wdata[2*NEXT-1:0];
          A_PCEN:  pc_en    <= bus_wdata[NGRP-1:0];
          A_M0:    pc_m0    <= bus_wdata;
          A_M1:    pc_m1    <= bus_wdata;
          A_M2:    pc_m2    <= bus_wdata;
          A_M3:    pc_m3    <= bus_wdata[G3W-1:0];
          default: ;
        endcase
    end

  assign irq_req = {pc_flag & pc_en, ext_act & ext_en} & {8{gie}};

  always_comb begin
    vec_id = '0;
    for (int i = 7; i >= 0; i--)
      if (irq_req[i]) vec_id = 3'(i);
  end
  assign vec_valid = |irq_req;
  assign ack_hot   = (vec_ack && vec_valid) ? (8'd1 << vec_id) : 8'd0;

  always_comb
    case (bus_addr)
      A_EFLG:  bus_rdata = 8'(ext_flag);
      A_EEN:   bus_rdata = 8'(ext_en);
      A_EMODE: bus_rdata = 8'(ext_mode);
      A_PCEN:  bus_rdata = 8'(pc_en);
      A_PCFLG: bus_rdata = 8'(pc_flag);
      A_M0:    bus_rdata = pc_m0;
      A_M1:    bus_rdata = pc_m1;
      A_M2:    bus_rdata = pc_m2;
      A_M3:    bus_rdata = 8'(pc_m3);
      default: bus_rdata = 8'd0;
    endcase
endmodule

module irq_event_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic [3:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic [7:0] irq_req,
  input logic       vec_valid,
  input logic [2:0] vec_id,
  input logic       vec_ack,
  input logic [7:0] ext_mode,
  input logic [3:0] ext_flag,
  input logic [3:0] ext_set,
  input logic [3:0] ext_clr,
  input logic [3:0] pc_flag,
  input logic [3:0] pc_set
);
  logic [3:0] lvl_now, lvl_prev;
  always_comb
    for (int i = 0; i < 4; i++) lvl_now[i] = (ext_mode[2*i +: 2] == 2'b00);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_prev <= 4'hF;
    else        lvl_prev <= lvl_now;

  // R4
  a_r4_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq_req == 8'd0);
  // R3
  a_r3_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag & lvl_now & lvl_prev) == 4'd0);
  // R11
  a_r11_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (irq_req != 8'd0));
  a_r11_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq_req[vec_id] && ((irq_req & ((8'd1 << vec_id) - 8'd1)) == 8'd0));
  // R8
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr inside {4'd0, 4'd1, 4'd3, 4'd4}) |-> bus_rdata[7:4] == 4'd0);
  // R6
  a_r6_ack_clears_group: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_valid && vec_id[2] && !pc_set[vec_id[1:0]]) |=> !pc_flag[$past(vec_id[1:0])]);
  // R7
  for (genvar i = 0; i < 4; i++) begin : g_sw
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_set[i] && ext_clr[i] && !lvl_now[i] && !(bus_wr && bus_addr == 4'd2)) |=> ext_flag[i]);
  end
endmodule

bind irq_event_ctrl irq_event_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_req(irq_req), .vec_valid(vec_valid), .vec_id(vec_id),
  .vec_ack(vec_ack), .ext_mode(ext_mode), .ext_flag(ext_flag), .ext_set(ext_set),
  .ext_clr(ext_clr), .pc_flag(pc_flag), .pc_set(pc_set)
);

// File: tb/test_irq_event_ctrl.sv
`timescale 1ns/1ps
module test_irq_event_ctrl;
  logic clk = 0, rst_n = 0, gie = 1, bus_wr = 0, vec_ack = 0;
  logic [3:0] ext_pin = '0, bus_addr = '0;
  logic [26:0] pc_pin = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, irq_req;
  logic vec_valid;
  logic [2:0] vec_id;

  irq_event_ctrl i_irq_event_ctrl (.*);

  always #4 clk = ~clk;

  typedef struct { bit kind; logic [11:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk)
    if (sb_q.size() != 0) begin
      item_t it;
      logic [11:0] act;
      it = sb_q.pop_front();
      act = it.kind ? {vec_valid, vec_id, irq_req} : {4'd0, bus_rdata};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end

  task automatic chk_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    sb_q.push_back('{1'b0, {4'd0, e}, tag});
    @(negedge clk); #1;
  endtask

  task automatic chk_vec(input bit v, input logic [2:0] id, input logic [7:0] rq, input string tag);
    @(posedge clk); #1;
    sb_q.push_back('{1'b1, {v, id, rq}, tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic ext_drive(input int i, input logic v);
    @(posedge clk); #1; ext_pin[i] = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic pc_drive(input int i, input logic v);
    @(posedge clk); #1; pc_pin[i] = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic ack();
    @(posedge clk); #1; vec_ack = 1;
    @(posedge clk); #1; vec_ack = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    for (int a = 0; a < 9; a++) chk_reg(4'(a), 8'h00, "R1 reset register");
    chk_vec(0, 0, 8'h00, "R1 reset request");
    // R8 / R10
    wr(1, 8'hFF); chk_reg(1, 8'h0F, "R8 enable reserved bits");
    wr(3, 8'hFF); chk_reg(3, 8'h0F, "R8 group enable reserved bits");
    wr(8, 8'hFF); chk_reg(8, 8'h07, "R10 group3 mask width");
    wr(1, 0); wr(3, 0); wr(8, 0);
    // R2: line0 rising, line1 falling, line2 any, line3 rising
    wr(2, 8'hDB);
    ext_drive(0, 1); chk_reg(0, 8'h01, "R2 rising edge");
    ext_drive(1, 1); chk_reg(0, 8'h01, "R2 rising ignored on falling line");
    ext_drive(1, 0); chk_reg(0, 8'h03, "R2 falling edge");
    ext_drive(0, 0); chk_reg(0, 8'h03, "R2 falling ignored on rising line");
    ext_drive(2, 1); chk_reg(0, 8'h07, "R2 any change");
    // R12 / R4
    chk_vec(0, 0, 8'h00, "R12 flags set with enables off");
    wr(1, 8'h01); chk_vec(1, 0, 8'h01, "R4 request with enable");
    gie = 0; chk_vec(0, 0, 8'h00, "R4 gie low blocks request");
    gie = 1;
    // R11 / R6
    wr(1, 8'h0F); chk_vec(1, 0, 8'h07, "R11 lowest line first");
    ack(); chk_reg(0, 8'h06, "R6 ack clears line0");
    chk_vec(1, 1, 8'h06, "R11 next line");
    ack(); chk_vec(1, 2, 8'h04, "R6 ack clears line1");
    // R5
    wr(0, 8'h00); chk_reg(0, 8'h04, "R5 write zero keeps flag");
    wr(0, 8'hF0); chk_reg(0, 8'h04, "R8 write to reserved flag bits ignored");
    wr(0, 8'h04); chk_reg(0, 8'h00, "R5 write one clears flag");
    // R7
    ext_drive(2, 0); chk_reg(0, 8'h04, "R2 any change falling");
    @(posedge clk); #1 ext_pin[2] = 1;
    @(posedge clk); @(posedge clk); #1;
    bus_addr = 0; bus_wdata = 8'h04; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
    chk_reg(0, 8'h04, "R7 set wins over write clear");
    wr(0, 8'h04); chk_reg(0, 8'h00, "R5 clear after collision");
    // R3
    ext_drive(3, 1); chk_reg(0, 8'h08, "R2 rising on line3");
    wr(2, 8'h1B); chk_reg(0, 8'h00, "R3 level mode forces flag zero");
    chk_vec(0, 0, 8'h00, "R3 high level no request");
    ext_drive(3, 0); chk_vec(1, 3, 8'h08, "R3 low level requests");
    @(posedge clk); #1 ext_pin[3] = 1;
    @(posedge clk); @(posedge clk);
    chk_vec(0, 0, 8'h00, "R3 request stops when high");
    wr(1, 0);
    // R9
    wr(5, 8'h01); wr(6, 8'h80); wr(8, 8'h04);
    pc_drive(1, 1); chk_reg(4, 8'h00, "R9 unmasked pin ignored");
    pc_drive(0, 1); chk_reg(4, 8'h01, "R9 masked pin rising");
    chk_vec(0, 0, 8'h00, "R12 group flag without group enable");
    wr(3, 8'h01); chk_vec(1, 4, 8'h10, "R4 group request");
    pc_drive(15, 1); chk_reg(4, 8'h03, "R9 group1 pin");
    pc_drive(23, 1); chk_reg(4, 8'h03, "R9 group2 unmasked");
    pc_drive(26, 1); chk_reg(4, 8'h0B, "R10 group3 pin 26");
    wr(4, 8'h01); chk_reg(4, 8'h0A, "R5 group write one clears");
    pc_drive(0, 0); chk_reg(4, 8'h0B, "R9 falling change");
    // R11 / R6 groups
    wr(3, 8'h0F); chk_vec(1, 4, 8'hB0, "R11 group0 first");
    ack(); chk_vec(1, 5, 8'hA0, "R6 ack clears group0");
    ack(); chk_vec(1, 7, 8'h80, "R6 ack clears group1");
    wr(1, 8'h08); ext_drive(3, 0);
    chk_vec(1, 3, 8'h88, "R11 external before group");
    wr(4, 8'h08); chk_reg(4, 8'h00, "R5 group3 cleared");
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule